// File: doc/BRIEF.md
# Debug Watchpoint Match Unit

A bank of four hardware watch slots placed beside a processor's fetch and load/store path. Software loads a watch address into each slot and describes all slots in one 32-bit control word: two enable bits per slot and a 4-bit type/length field per slot. Every cycle the block compares the presented access (an instruction fetch, a data read or a data write, with its byte address and byte count) against every enabled slot. On a match it raises a one-cycle trap request and sets a sticky per-slot hit bit in a status word.

Software reaches the slot addresses, the status word and the control word through a single-cycle register port with a 3-bit index. A task-switch pulse drops the per-task (local) enables while the global enables survive. Reserved control bits cannot be written. There is no state machine. The block is a register file, one combinational comparator per slot and a trap flop.

Top module: `dbgw_unit`

## Requirements
- R1: After reset every register read (indices 0 to 7) returns zero, so every slot is vacant and `trap_req` is low.
- R2: Register indices 0 to 3 hold the watch addresses of slots 0 to 3 and read back what was written. Indices 4 and 5 read as zero, and writes to them change nothing. Reads are combinational on `reg_idx`, and writes take effect at the clock edge where `reg_wr_en` is high.
- R3: The control word is at index 7. Bits 15:10 ignore writes and read as zero. Bits 8 and 9 are stored and read back, and have no effect on matching.
- R4: Slot i is enabled by control bit 2i (local) or bit 2i+1 (global). When both bits are zero the slot never hits.
- R5: A `task_switch` pulse clears control bits 0, 2, 4 and 6 at the clock edge, after any same-cycle control write has been applied. Bits 1, 3, 5 and 7 are never cleared by hardware.
- R6: For slot i, control bits [17+4i:16+4i] are the type: 0 is execute, 1 is data write only, 3 is data read or write, and 2 never matches. Bits [19+4i:18+4i] are the length. Access kinds on `acc_kind` are 0 for fetch, 1 for read, 2 for write and 3 for none.
- R7: Length code 0 is 1 byte, code 1 is 2 bytes and code 3 is 4 bytes. The watched region is the slot address rounded down to a multiple of the length, spanning that length. A data access of 2^`acc_size` bytes at `acc_addr` hits if any of its bytes falls in that region.
- R8: Length code 2 is 8 bytes when parameter `ALLOW_LEN8` is 1. When it is 0, a data slot with code 2 never matches.
- R9: An execute slot hits only on a fetch whose address equals the slot address exactly, whatever the length field holds. Data slots never hit on fetches.
- R10: A hit sets status bit i (index 6) at the clock edge after the access. The bit stays set until a status write. A status write loads `reg_wdata[3:0]`, and hits in the same cycle are ORed on top.
- R11: `trap_req` is high for exactly the cycle after each cycle that has at least one hit. Several slots may hit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` |
| task_switch | input | 1 | One-cycle task-switch pulse |
| acc_valid | input | 1 | Access present this cycle |
| acc_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 none |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_size | input | 2 | Access size as log2 of its byte count |
| trap_req | output | 1 | Debug trap request, one cycle per hitting access |

## Verification
The bench sweeps every type and length code against every access kind and size, using unaligned slot addresses and access addresses on both sides of each watched region. It runs this sweep on two instances, one with the 8-byte length allowed and one without. A comparator that skipped the round-down of the slot address, or that tested overlap against only the first byte of the access, would miss hits near region edges or report false ones. So would a comparator that read length code 2 as 4 bytes. Directed cases cover the rest:
- A task switch with mixed local and global enables; clearing the global bits would silence a slot that should still hit.
- A status write that lands in the same cycle as a hit; letting the write win would lose the hit.
- All four slots hitting at once; a design that kept only one status bit would fail here.
- A check that the trap falls back to low on the following idle cycle; a sticky trap would fail here.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_NONE  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        WT_EXEC  = 2'd0,
        WT_WRITE = 2'd1,
        WT_IO    = 2'd2,
        WT_RDWR  = 2'd3
    } watch_type_e;

    localparam int          REG_W       = 32;
    localparam int          IDX_W       = 3;
    localparam logic [2:0]  IDX_STATUS  = 3'd6;
    localparam logic [2:0]  IDX_CTRL    = 3'd7;
    localparam int          FIELD_BASE  = 16;
    localparam int          FIELD_W     = 4;
    localparam logic [31:0] CTRL_KEEP   = 32'hFFFF_03FF;

    // Byte count for a length code; zero means the code never matches.
    function automatic logic [3:0] len_bytes(input logic [1:0] code, input bit allow8);
        logic [3:0] n;
        unique case (code)
            2'd0: n = 4'd1;
            2'd1: n = 4'd2;
            2'd3: n = 4'd4;
            2'd2: n = allow8 ? 4'd8 : 4'd0;
        endcase
        return n;
    endfunction

    // Mask of the per-slot local enable bits (even positions).
    function automatic logic [31:0] local_mask(input int nslot);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < nslot; i++) m[2*i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/dbgw_slot_cmp.sv
module dbgw_slot_cmp
    import dbgw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter bit ALLOW_LEN8 = 1'b1
) (
    input  logic [ADDR_W-1:0] slot_addr,
    input  logic [1:0]        slot_en,
    input  logic [3:0]        type_len,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    output logic              hit
);
    localparam int XW = ADDR_W + 1;

    logic [3:0]    rlen;
    logic [XW-1:0] base_x, rend_x, abeg_x, aend_x;
    logic          kind_ok, exec_ok, data_ok;
    watch_type_e   wtype;

    always_comb begin
        wtype  = watch_type_e'(type_len[1:0]);
        rlen   = len_bytes(type_len[3:2], ALLOW_LEN8);
        base_x = {1'b0, slot_addr & ~(ADDR_W'(rlen) - ADDR_W'(1))};
        rend_x = base_x + XW'(rlen);
        abeg_x = {1'b0, acc_addr};
        aend_x = abeg_x + (XW'(1) << acc_size);

        unique case (wtype)
            WT_EXEC:  kind_ok = (acc_kind == ACC_FETCH);
            WT_WRITE: kind_ok = (acc_kind == ACC_WRITE);
            WT_RDWR:  kind_ok = (acc_kind == ACC_READ) || (acc_kind == ACC_WRITE);
            WT_IO:    kind_ok = 1'b0;
        endcase

        exec_ok = (wtype == WT_EXEC) && (acc_addr == slot_addr);
        data_ok = (wtype != WT_EXEC) && (rlen != 4'd0)
                  && (abeg_x < rend_x) && (base_x < aend_x);
        hit     = acc_valid && (|slot_en) && kind_ok && (exec_ok || data_ok);
    end

endmodule

// File: rtl/dbgw_regs.sv
module dbgw_regs
    import dbgw_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 idx,
    input  logic [REG_W-1:0]                 wdata,
    input  logic                             task_sw,
    input  logic [NUM_SLOTS-1:0]             hit_vec,
    output logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr,
    output logic [REG_W-1:0]                 ctrl_q,
    output logic [NUM_SLOTS-1:0]             status_q,
    output logic [REG_W-1:0]                 rdata
);
    localparam logic [REG_W-1:0] LOC_MASK = local_mask(NUM_SLOTS);
    localparam logic [REG_W-1:0] GLB_MASK = LOC_MASK << 1;

    logic [REG_W-1:0]     ctrl_nxt;
    logic [NUM_SLOTS-1:0] status_nxt;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_addr
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_addr[i] <= '0;
            else if (wr_en && idx == IDX_W'(i))
                slot_addr[i] <= wdata[ADDR_W-1:0];
        end
    end

    always_comb begin
        ctrl_nxt = ctrl_q;
        if (wr_en && idx == IDX_CTRL) ctrl_nxt = wdata & CTRL_KEEP;
        if (task_sw)                  ctrl_nxt = ctrl_nxt & ~LOC_MASK;
        status_nxt = status_q;
        if (wr_en && idx == IDX_STATUS) status_nxt = wdata[NUM_SLOTS-1:0];
        status_nxt = status_nxt | hit_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            status_q <= '0;
        end else begin
            ctrl_q   <= ctrl_nxt;
            status_q <= status_nxt;
        end
    end

    always_comb begin
        rdata = '0;
        if (idx == IDX_CTRL)
            rdata = ctrl_q;
        else if (idx == IDX_STATUS)
            rdata = REG_W'(status_q);
        else if (int'(idx) < NUM_SLOTS)
            rdata = REG_W'(slot_addr[idx[1:0]]);
    end

    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[15:10] == 6'd0);

    p_task_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        task_sw |=> ((ctrl_q & LOC_MASK) == '0));

    p_global_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (task_sw && !(wr_en && idx == IDX_CTRL)) |=> $stable(ctrl_q & GLB_MASK));

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && idx == IDX_STATUS) |=> ((status_q & $past(status_q)) == $past(status_q)));

endmodule

// File: rtl/dbgw_unit.sv
module dbgw_unit
    import dbgw_pkg::*;
#(
    parameter int NUM_SLOTS  = 4,
    parameter int ADDR_W     = 32,
    parameter bit ALLOW_LEN8 = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_idx,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              task_switch,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    output logic              trap_req
);
    localparam int EN_BITS = 2 * NUM_SLOTS;

    logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr;
    logic [REG_W-1:0]                 ctrl_q;
    logic [NUM_SLOTS-1:0]             status_q;
    logic [NUM_SLOTS-1:0]             hit_vec;
    logic                             trap_q;

    dbgw_regs #(
        .NUM_SLOTS (NUM_SLOTS),
        .ADDR_W    (ADDR_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .idx       (reg_idx),
        .wdata     (reg_wdata),
        .task_sw   (task_switch),
        .hit_vec   (hit_vec),
        .slot_addr (slot_addr),
        .ctrl_q    (ctrl_q),
        .status_q  (status_q),
        .rdata     (reg_rdata)
    );

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        dbgw_slot_cmp #(
            .ADDR_W     (ADDR_W),
            .ALLOW_LEN8 (ALLOW_LEN8)
        ) cmp_i (
            .slot_addr (slot_addr[i]),
            .slot_en   (ctrl_q[2*i+1 -: 2]),
            .type_len  (ctrl_q[FIELD_BASE + FIELD_W*i +: FIELD_W]),
            .acc_valid (acc_valid),
            .acc_kind  (acc_kind),
            .acc_addr  (acc_addr),
            .acc_size  (acc_size),
            .hit       (hit_vec[i])
        );

        p_io_never_r6: assert property (@(posedge clk) disable iff (!rst_n)
            hit_vec[i] |-> (ctrl_q[FIELD_BASE + FIELD_W*i +: 2] != WT_IO));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trap_q <= 1'b0;
        else        trap_q <= |hit_vec;
    end

    assign trap_req = trap_q;

    p_trap_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> (status_q != '0));

    p_trap_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> $past(|ctrl_q[EN_BITS-1:0]));

endmodule

// File: tb/dbgw_unit_tb_top.sv
module dbgw_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_idx = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic        task_switch = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_kind = 2'd3;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_size = 2'd0;
    logic        trap_a, trap_b;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    dbgw_unit #(.ALLOW_LEN8(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_a), .task_switch(task_switch),
        .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_addr(acc_addr),
        .acc_size(acc_size), .trap_req(trap_a));

    dbgw_unit #(.ALLOW_LEN8(1'b0)) dut_n8 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_b), .task_switch(task_switch),
        .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_addr(acc_addr),
        .acc_size(acc_size), .trap_req(trap_b));

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] i, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_idx = i; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] i, input logic [31:0] exp, input string tag);
        reg_idx = i;
        #1;
        chk(rdata_a, exp, tag);
        chk(rdata_b, exp, tag);
    endtask

    // Present one access; after the capturing edge check trap and status.
    task automatic acc(input logic [1:0] k, input logic [31:0] a, input logic [1:0] sz,
                       input bit ea, input bit eb, input int s, input string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_kind = k; acc_addr = a; acc_size = sz;
        @(negedge clk);
        acc_valid = 1'b0; acc_kind = 2'd3; reg_idx = 3'd6;
        #1;
        chk(32'(trap_a), 32'(ea), tag);
        chk(32'(trap_b), 32'(eb), tag);
        chk(rdata_a, 32'(ea) << s, tag);
        chk(rdata_b, 32'(eb) << s, tag);
        wr(3'd6, 32'd0);
    endtask

    function automatic bit exp_hit(input int typ, input int len, input longint sa,
                                   input int kind, input longint a, input int sz, input bit l8);
        int     lb;
        longint base;
        if (typ == 2) return 1'b0;
        if (typ == 0) return (kind == 0) && (a == sa);
        if (typ == 1 && kind != 2) return 1'b0;
        if (typ == 3 && kind == 0) return 1'b0;
        lb = (len == 0) ? 1 : (len == 1) ? 2 : (len == 3) ? 4 : (l8 ? 8 : 0);
        if (lb == 0) return 1'b0;
        base = sa - (sa % lb);
        return (a < base + lb) && (base < a + (64'd1 << sz));
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 8; i++) rd_chk(3'(i), 32'd0, "R1 reset read");
        chk(32'(trap_a), 32'd0, "R1 trap after reset");

        // R2: address registers and unused indices
        for (int i = 0; i < 4; i++) wr(3'(i), 32'hA000_0000 + 32'(i * 17));
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd5, 32'h1234_5678);
        for (int i = 0; i < 4; i++) rd_chk(3'(i), 32'hA000_0000 + 32'(i * 17), "R2 addr readback");
        rd_chk(3'd4, 32'd0, "R2 idx4 zero");
        rd_chk(3'd5, 32'd0, "R2 idx5 zero");

        // R3: reserved control bits
        wr(3'd7, 32'hFFFF_FFFF);
        rd_chk(3'd7, 32'hFFFF_03FF, "R3 reserved masked");
        wr(3'd7, 32'd0);

        // R4: vacant slot, then local-only and global-only
        wr(3'd0, 32'h0000_2000);
        wr(3'd7, 32'h000F_0000);
        acc(2'd1, 32'h2000, 2'd0, 1'b0, 1'b0, 0, "R4 vacant slot");
        wr(3'd7, 32'h000F_0001);
        acc(2'd1, 32'h2000, 2'd0, 1'b1, 1'b1, 0, "R4 local enable");
        wr(3'd7, 32'h000F_0002);
        acc(2'd1, 32'h2000, 2'd0, 1'b1, 1'b1, 0, "R4 global enable");

        // R5: task switch clears local enables only
        wr(3'd1, 32'h0000_3000);
        wr(3'd7, 32'h00FF_0000 | 32'h0000_0009);  // slot0 local, slot1 global
        @(negedge clk); task_switch = 1'b1;
        @(negedge clk); task_switch = 1'b0;
        rd_chk(3'd7, 32'h00FF_0008, "R5 local cleared");
        acc(2'd2, 32'h2000, 2'd0, 1'b0, 1'b0, 0, "R5 local slot silenced");
        acc(2'd2, 32'h3000, 2'd0, 1'b1, 1'b1, 1, "R5 global slot survives");

        // R10/R11: four slots at once, trap lasts one cycle, status sticky
        for (int i = 0; i < 4; i++) wr(3'(i), 32'h0000_4000);
        wr(3'd7, 32'hFFFF_00AA);
        @(negedge clk);
        acc_valid = 1'b1; acc_kind = 2'd2; acc_addr = 32'h4000; acc_size = 2'd0;
        @(negedge clk);
        acc_valid = 1'b0; acc_kind = 2'd3;
        chk(32'(trap_a), 32'd1, "R11 trap after multi hit");
        rd_chk(3'd6, 32'hF, "R11 all four status bits");
        @(negedge clk);
        chk(32'(trap_a), 32'd0, "R11 trap one cycle only");
        repeat (3) @(negedge clk);
        rd_chk(3'd6, 32'hF, "R10 status sticky");
        wr(3'd6, 32'd0);
        rd_chk(3'd6, 32'h0, "R10 status cleared by write");
        // status write in the same cycle as a hit on slot 0
        wr(3'd7, 32'h000F_0002);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_idx = 3'd6; reg_wdata = 32'h2;
        acc_valid = 1'b1; acc_kind = 2'd1; acc_addr = 32'h4000; acc_size = 2'd0;
        @(negedge clk);
        reg_wr_en = 1'b0; acc_valid = 1'b0; acc_kind = 2'd3;
        rd_chk(3'd6, 32'h3, "R10 hit wins over status write");
        wr(3'd6, 32'd0);

        // Sweep: R6 R7 R8 R9 across slots, codes, kinds, sizes, addresses
        for (int s = 0; s < 4; s++) begin
            longint sa;
            sa = 64'h1000 + longint'(s * 64) + longint'((s * 3 + 5) % 8);
            wr(3'(s), 32'(sa));
            for (int t = 0; t < 4; t++) begin
                for (int l = 0; l < 4; l++) begin
                    logic [31:0] cw;
                    string tag;
                    cw = 32'(((s % 2) ? 1 : 2) << (2 * s));
                    cw = cw | (32'((l << 2) | t) << (16 + 4 * s));
                    if (s % 2) cw = cw | 32'h300;  // R3: bits 8 and 9 must not matter
                    wr(3'd7, cw);
                    tag = (t == 0) ? "R9 exec sweep" : (t == 2) ? "R6 io never" :
                          (l == 2) ? "R8 eight-byte" : "R7 data overlap";
                    for (int k = 0; k < 3; k++)
                        for (int z = 0; z < 4; z++)
                            for (int d = -12; d <= 12; d++) begin
                                longint a;
                                a = sa + longint'(d);
                                acc(2'(k), 32'(a), 2'(z),
                                    exp_hit(t, l, sa, k, a, z, 1'b1),
                                    exp_hit(t, l, sa, k, a, z, 1'b0), s, tag);
                            end
                end
            end
            wr(3'd7, 32'd0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule